// File: doc/BRIEF.md
# Triggered Down-Counting Waveform Timer

This block is one channel of a waveform generator. A 16-bit down-counter is started by a trigger and drives a pulse on the waveform pin. The pin is high from the clock after the trigger until the counter runs out. A 3-bit mode input chooses what counts as a trigger. It can be the level of the timer-trigger input, its rising edge, either of its edges, or either edge of a PWM input. The timer-trigger input first passes through a programmable noise canceller, so short glitches cannot start a pulse.

Software sets a reload value, a prescaler select and a filter width. A reload value written while a pulse is running is held. It takes effect only when the next trigger loads the counter. Each underflow sets a sticky flag, which stays set until a clear strobe removes it. The interrupt request is this flag gated by an enable input.

Top module: `wavetrig_timer`

## Requirements
- R1: After reset, `wave_out`, `irq_flag` and `irq` are all low.
- R2: With mode 3'b001, a trigger occurs whenever the filtered trigger input is high and no count is running. If that input is still high when the counter underflows, the timer re-arms after exactly one low cycle on `wave_out`.
- R3: With mode 3'b010, a rising edge of the filtered trigger input starts a count. `wave_out` is high in the first sample after the clock edge that sees the edge.
- R4: With mode 3'b100, a rising or a falling edge of the filtered trigger input starts a count.
- R5: With mode 3'b111, a rising or a falling edge of `pwm_in` starts a count, and the trigger input is ignored.
- R6: Mode values 3'b000, 3'b011, 3'b101 and 3'b110 never trigger, and `wave_out` stays low while they are selected.
- R7: After a trigger, `wave_out` stays high for exactly (N+1)·2^D clock cycles and then goes low. N is the reload value loaded at the trigger and D is `div_sel`, which gives a divide ratio of 2^D.
- R8: A value written with `reload_we` is held and is used only at the next trigger. In the edge modes, a new qualifying edge during a count restarts the count from the held value.
- R9: Any change of `mode` cancels a running count, so `wave_out` is low one clock after the change. No trigger is taken in the cycle the change is seen.
- R10: An underflow sets `irq_flag`. The flag stays set until `flag_clr` is asserted, and an underflow in the same cycle as `flag_clr` wins. `irq` is high exactly when both `irq_flag` and `irq_en` are high.
- R11: `nf_sel` = 0 passes the trigger input through unfiltered. Values 1, 2 and 3 pass a level change only after it has been stable for 4, 8 and 16 clocks, which adds that many cycles of trigger latency. Shorter pulses are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_in | input | 1 | Timer-trigger input (noise-filtered) |
| pwm_in | input | 1 | PWM edge trigger input |
| mode | input | 3 | Trigger mode select |
| reload_val | input | 16 | Reload value to write |
| reload_we | input | 1 | Write strobe for the reload holding register |
| div_sel | input | 3 | Prescaler select, divide ratio 2^div_sel |
| nf_sel | input | 2 | Noise-filter width select |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the underflow flag |
| wave_out | output | 1 | Waveform pin |
| irq_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven through every trigger mode, each with a different reload value, prescaler ratio and filter width. Checking both the trigger-to-output latency and the pulse length separates filter delay from prescaler scaling. Falling-edge stimulus in the both-edge and PWM modes catches a decoder that only watches rising edges. A steady high level in level mode exposes missing re-arm behaviour. Directed cases then apply each of the following and check the result:
- a glitch shorter than the filter width,
- a reload write during a count, followed by a retrigger,
- a mode change in mid-pulse,
- an unused mode code,
- a cleared interrupt enable.

// File: rtl/wavetrig_pkg.sv
package wavetrig_pkg;
  localparam int DIV_W = 3;
  localparam int NF_W  = 2;
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam int FLT_W = (1 << NF_W);

  localparam logic [2:0] MODE_LEVEL = 3'b001;
  localparam logic [2:0] MODE_RISE  = 3'b010;
  localparam logic [2:0] MODE_BOTH  = 3'b100;
  localparam logic [2:0] MODE_PWM   = 3'b111;

  function automatic logic mode_valid(logic [2:0] m);
    return (m == MODE_LEVEL) || (m == MODE_RISE) || (m == MODE_BOTH) || (m == MODE_PWM);
  endfunction

  function automatic logic trig_decide(logic [2:0] m, logic rt, logic rt_p,
                                       logic pw, logic pw_p, logic busy);
    logic t;
    case (m)
      MODE_LEVEL: t = rt & ~busy;
      MODE_RISE:  t = rt & ~rt_p;
      MODE_BOTH:  t = rt ^ rt_p;
      MODE_PWM:   t = pw ^ pw_p;
      default:    t = 1'b0;
    endcase
    return t;
  endfunction

  // low-order ones mask: tick when the masked prescale count is all ones
  function automatic logic [PRE_W-1:0] div_mask(logic [DIV_W-1:0] sel);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(sel));
    return m;
  endfunction

  // required stable time in clocks; 0 means bypass
  function automatic logic [FLT_W:0] flt_width(logic [NF_W-1:0] sel);
    logic [FLT_W:0] w;
    w = '0;
    if (sel != '0) w[{1'b0, sel} + 1'b1] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/wt_deglitch.sv
module wt_deglitch
  import wavetrig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF_W-1:0] sel,
  input  logic            din,
  output logic            dout
);
  logic             level_q;
  logic [FLT_W-1:0] cnt_q;
  logic [FLT_W:0]   width;

  assign width = flt_width(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sel == '0 || din == level_q) begin
      level_q <= din;
      cnt_q   <= '0;
    end else if (({1'b0, cnt_q} + (FLT_W+1)'(1)) == width) begin
      level_q <= din;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = (sel == '0) ? din : level_q;
endmodule

// File: rtl/wt_prescale.sv
module wt_prescale
  import wavetrig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(sel);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wt_trigger.sv
module wt_trigger
  import wavetrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       rt_f,
  input  logic       pwm,
  input  logic       busy,
  output logic       mode_chg,
  output logic       trig
);
  logic       rt_p, pw_p;
  logic [2:0] mode_q;

  assign mode_chg = (mode != mode_q);
  assign trig     = !mode_chg && trig_decide(mode, rt_f, rt_p, pwm, pw_p, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_p   <= 1'b0;
      pw_p   <= 1'b0;
      mode_q <= 3'b000;
    end else begin
      rt_p   <= rt_f;
      pw_p   <= pwm;
      mode_q <= mode;
    end
  end
endmodule

// File: rtl/wavetrig_timer.sv
module wavetrig_timer
  import wavetrig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rt_in,
  input  logic             pwm_in,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_we,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [NF_W-1:0]  nf_sel,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic             wave_out,
  output logic             irq_flag,
  output logic             irq
);
  logic             rt_f;
  logic             trig_evt, mode_chg, tick, uf_evt;
  logic             running_q, flag_q;
  logic [CNT_W-1:0] held_q, cnt_q;

  wt_deglitch u_flt (
    .clk(clk), .rst_n(rst_n), .sel(nf_sel), .din(rt_in), .dout(rt_f)
  );

  wt_trigger u_trg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rt_f(rt_f), .pwm(pwm_in),
    .busy(running_q), .mode_chg(mode_chg), .trig(trig_evt)
  );

  wt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(trig_evt), .run(running_q),
    .sel(div_sel), .tick(tick)
  );

  assign uf_evt = running_q && tick && (cnt_q == '0) && !trig_evt && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= '0;
      cnt_q     <= '0;
      running_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (reload_we) held_q <= reload_val;
      if (mode_chg) begin
        running_q <= 1'b0;
      end else if (trig_evt) begin
        cnt_q     <= held_q;
        running_q <= 1'b1;
      end else if (tick) begin
        if (cnt_q == '0) running_q <= 1'b0;
        else             cnt_q     <= cnt_q - 1'b1;
      end
      if (uf_evt)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign wave_out = running_q;
  assign irq_flag = flag_q;
  assign irq      = flag_q & irq_en;
endmodule

// File: rtl/wavetrig_checker.sv
module wavetrig_checker
  import wavetrig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       wave_out,
  input logic       irq_flag,
  input logic       irq,
  input logic       irq_en,
  input logic       flag_clr,
  input logic       trig_evt,
  input logic       uf_evt,
  input logic       mode_chg
);
  a_r7_trigger_raises: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> wave_out);

  a_r7_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wave_out) |-> $past(uf_evt || mode_chg));

  a_r10_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> irq_flag);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && irq_flag));

  a_r9_change_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !wave_out);

  a_r6_idle_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_valid(mode) |-> !trig_evt);
endmodule

bind wavetrig_timer wavetrig_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wave_out(wave_out),
  .irq_flag(irq_flag), .irq(irq), .irq_en(irq_en), .flag_clr(flag_clr),
  .trig_evt(trig_evt), .uf_evt(uf_evt), .mode_chg(mode_chg)
);

// File: tb/test_wavetrig_timer.sv
module test_wavetrig_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rt_in = 1'b0, pwm_in = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [15:0] reload_val = '0;
  logic        reload_we = 1'b0;
  logic [2:0]  div_sel = '0;
  logic [1:0]  nf_sel = '0;
  logic        irq_en = 1'b0, flag_clr = 1'b0;
  logic        wave_out, irq_flag, irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  wavetrig_timer i_wavetrig_timer (
    .clk(clk), .rst_n(rst_n), .rt_in(rt_in), .pwm_in(pwm_in), .mode(mode),
    .reload_val(reload_val), .reload_we(reload_we), .div_sel(div_sel),
    .nf_sel(nf_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .wave_out(wave_out), .irq_flag(irq_flag), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        use_pwm;
    logic        init_lvl;
    logic [15:0] reload;
    logic [2:0]  dsel;
    logic [1:0]  nsel;
    logic [7:0]  lat;
    logic [15:0] hi;
  } vec_t;

  // hi = (reload+1) << dsel ; lat = 1 + filter width
  localparam vec_t VECS [7] = '{
    '{3'b010, 1'b0, 1'b0, 16'd3, 3'd0, 2'd0, 8'd1,  16'd4},
    '{3'b010, 1'b0, 1'b0, 16'd2, 3'd2, 2'd1, 8'd5,  16'd12},
    '{3'b100, 1'b0, 1'b1, 16'd0, 3'd0, 2'd0, 8'd1,  16'd1},
    '{3'b100, 1'b0, 1'b0, 16'd5, 3'd1, 2'd2, 8'd9,  16'd12},
    '{3'b111, 1'b1, 1'b1, 16'd7, 3'd3, 2'd0, 8'd1,  16'd64},
    '{3'b111, 1'b1, 1'b0, 16'd1, 3'd0, 2'd0, 8'd1,  16'd2},
    '{3'b001, 1'b0, 1'b0, 16'd4, 3'd0, 2'd3, 8'd17, 16'd5}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reload(logic [15:0] v);
    reload_val = v; reload_we = 1'b1;
    cyc(1);
    reload_we = 1'b0;
  endtask

  task automatic measure(output int lat, output int hi);
    lat = 0; hi = 0;
    while (lat < 200) begin
      cyc(1); lat++;
      if (wave_out) break;
    end
    hi = 1;
    while (hi < 2000) begin
      cyc(1);
      if (!wave_out) break;
      hi++;
    end
  endtask

  task automatic clear_flag();
    mode = 3'b000;
    cyc(2);
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat, hi;
    string tag;
    cyc(2);
    chk("R1 wave", 32'(wave_out), 0);
    chk("R1 flag", 32'(irq_flag), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 wave after release", 32'(wave_out), 0);
    chk("R1 irq after release", 32'(irq), 0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      mode = 3'b000; irq_en = 1'b1;
      rt_in = v.use_pwm ? 1'b0 : v.init_lvl;
      pwm_in = v.use_pwm ? v.init_lvl : 1'b0;
      div_sel = v.dsel; nf_sel = v.nsel;
      write_reload(v.reload);
      cyc(20);
      mode = v.mode;
      cyc(3);
      if (v.use_pwm) pwm_in = ~pwm_in; else rt_in = ~rt_in;
      measure(lat, hi);
      case (v.mode)
        3'b001:  tag = "R2";
        3'b010:  tag = "R3";
        3'b100:  tag = "R4";
        default: tag = "R5";
      endcase
      chk({tag, (v.nsel != 0) ? " R11 latency" : " latency"}, lat, 32'(v.lat));
      chk({"R7 width ", tag}, hi, 32'(v.hi));
      chk("R10 flag set", 32'(irq_flag), 1);
      chk("R10 irq enabled", 32'(irq), 1);
      if (v.mode == 3'b001) begin
        cyc(1);
        chk("R2 re-arm after one low cycle", 32'(wave_out), 1);
      end
      clear_flag();
      chk("R10 flag cleared", 32'(irq_flag), 0);
    end

    // R8: held reload, restart on new edge
    rt_in = 1'b0; div_sel = 3'd0; nf_sel = 2'd0; pwm_in = 1'b0;
    write_reload(16'd20);
    cyc(3);
    mode = 3'b010;
    cyc(3);
    rt_in = 1'b1;
    cyc(5);
    write_reload(16'd2);
    chk("R8 running value unchanged by write", 32'(wave_out), 1);
    rt_in = 1'b0;
    cyc(2);
    chk("R8 still high", 32'(wave_out), 1);
    rt_in = 1'b1;
    measure(lat, hi);
    chk("R8 restart from held value", hi, 3);
    clear_flag();

    // R9: mode change during pulse
    write_reload(16'd30);
    rt_in = 1'b0;
    cyc(2);
    mode = 3'b010;
    cyc(3);
    rt_in = 1'b1;
    cyc(4);
    chk("R9 pulse running", 32'(wave_out), 1);
    mode = 3'b100;
    cyc(1);
    chk("R9 low one clock after change", 32'(wave_out), 0);
    cyc(3);
    chk("R9 stays low", 32'(wave_out), 0);
    clear_flag();

    // R6: unused mode code
    mode = 3'b011; rt_in = 1'b0; pwm_in = 1'b0;
    write_reload(16'd3);
    cyc(3);
    begin
      int highs = 0;
      for (int k = 0; k < 12; k++) begin
        rt_in = ~rt_in; pwm_in = ~pwm_in;
        cyc(1);
        if (wave_out) highs++;
      end
      chk("R6 no output in unused mode", highs, 0);
    end

    // R11: glitch shorter than filter width
    mode = 3'b000; rt_in = 1'b0; nf_sel = 2'd1;
    cyc(10);
    mode = 3'b010;
    cyc(3);
    rt_in = 1'b1;
    cyc(3);
    rt_in = 1'b0;
    begin
      int highs = 0;
      for (int k = 0; k < 12; k++) begin
        cyc(1);
        if (wave_out) highs++;
      end
      chk("R11 short glitch discarded", highs, 0);
    end

    // R10: enable gating
    mode = 3'b000; nf_sel = 2'd0; irq_en = 1'b0;
    write_reload(16'd0);
    cyc(2);
    mode = 3'b010;
    cyc(3);
    rt_in = 1'b1;
    cyc(4);
    chk("R10 flag set with enable low", 32'(irq_flag), 1);
    chk("R10 irq masked", 32'(irq), 0);
    irq_en = 1'b1;
    cyc(1);
    chk("R10 irq follows enable", 32'(irq), 1);
    clear_flag();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule